// File: doc/BRIEF.md
# Cost-Weighted Victim Selector for One Cache Set

This block picks which way of one set-associative cache set is to be replaced. Each way has a recency position, where 0 is the least recently used and WAYS-1 the most recently used. Each way also has a small quantized miss cost, which was recorded when its line was filled. The replacement candidate is the way with the lowest score. The score is the way's position plus an external weight times its stored cost. So a line that was expensive to fetch is kept longer than its age alone would allow.

The surrounding cache controller supplies four things: the valid bits of the set, the weight, a mode bit, and two update ports. The hit port marks a way as just used. The fill port marks a newly installed way as just used and stores the cost that the miss-cost logic measured for it. The victim output is combinational, so the controller can read it in the same cycle it needs it. When the mode bit is set, the cost term is dropped and the block behaves as a plain least-recently-used selector. The tag and data arrays and the cost measurement itself live elsewhere.

Top module: `lin_victim_select`

## Requirements
- R1: After reset, way i holds recency position i and every stored cost is 0. With all ways valid, the victim is therefore way 0 for any weight.
- R2: On a clock edge with an update, the updated way takes position WAYS-1. Every way whose position was above the updated way's old position drops by one. All other ways keep their position.
- R3: On a clock edge with fill_en high, fill_cost is stored as the cost of fill_way. A hit leaves every stored cost unchanged.
- R4: Each way's score is its position plus cost_weight times its stored cost, computed without overflow. victim_way is the valid way with the smallest score. It is combinational in the current state and inputs.
- R5: When mode_lru is 1, cost_weight is treated as 0, and the victim is the valid way with the smallest position.
- R6: A way whose way_valid bit is 0 is chosen before any valid way. Among invalid ways, the lowest index is chosen.
- R7: When several valid ways share the smallest score, the lowest index is chosen.
- R8: When hit_en and fill_en are both high in one cycle, only the fill is applied, and the hit has no effect.
- R9: On a clock edge with neither hit_en nor fill_en high, no position and no stored cost changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_en | input | 1 | A hit to hit_way occurred this cycle |
| hit_way | input | IDX_W | Way that was hit |
| fill_en | input | 1 | A line is installed in fill_way this cycle |
| fill_way | input | IDX_W | Way receiving the new line |
| fill_cost | input | COST_W | Quantized miss cost of the new line |
| way_valid | input | WAYS | Valid bit of each way, 1 = holds a line |
| mode_lru | input | 1 | 1 = ignore cost, plain LRU choice |
| cost_weight | input | WEIGHT_W | Multiplier S applied to the stored cost |
| victim_way | output | IDX_W | Way chosen for replacement |

## Verification
The victim is a pure function of the current state and the present inputs, so it is due in the same cycle as any change to way_valid, mode_lru or cost_weight. The effect of a hit or fill appears only after the next rising edge. The bench drives inputs just after a falling edge. It updates its reference model and queues the expected victim just after the following rising edge. The monitor compares each queued item at the next falling edge, which is the first point where both the registered update and the combinational choice have settled, and before the driver moves on. A directed sequence builds a score tie and a set with holes, and a pseudo-random run mixes hits, fills, simultaneous hit and fill, mode and weight changes.

// File: rtl/lin_pkg.sv
package lin_pkg;
  localparam int unsigned LIN_WAYS_DEF     = 16;
  localparam int unsigned LIN_COST_W_DEF   = 3;
  localparam int unsigned LIN_WEIGHT_W_DEF = 3;

  // Width that holds (WAYS-1) + (2^WEIGHT_W-1)*(2^COST_W-1) without overflow.
  function automatic int unsigned lin_score_w(input int unsigned pos_w,
                                              input int unsigned cost_w,
                                              input int unsigned weight_w);
    return pos_w + cost_w + weight_w + 1;
  endfunction
endpackage

// File: rtl/lin_recency_stack.sv
module lin_recency_stack #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned POS_W = $clog2(WAYS),
  parameter int unsigned IDX_W = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            upd_en,
  input  logic [IDX_W-1:0]                upd_way,
  output logic [WAYS-1:0][POS_W-1:0]      pos_q
);
  localparam logic [POS_W-1:0] TOP_POS = POS_W'(WAYS - 1);

  logic [POS_W-1:0]             old_pos;
  logic [WAYS-1:0][POS_W-1:0]   pos_d;
  logic [WAYS-1:0]              pos_we;

  assign old_pos = pos_q[upd_way];

  always_comb begin
    for (int i = 0; i < WAYS; i++) begin
      pos_d[i]  = pos_q[i];
      pos_we[i] = 1'b0;
      if (upd_en) begin
        if (upd_way == IDX_W'(i)) begin
          pos_d[i]  = TOP_POS;
          pos_we[i] = 1'b1;
        end else if (pos_q[i] > old_pos) begin
          pos_d[i]  = pos_q[i] - 1'b1;
          pos_we[i] = 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_pos
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q[g] <= POS_W'(g);
      end else if (pos_we[g]) begin
        pos_q[g] <= pos_d[g];
      end
    end
  end
endmodule

// File: rtl/lin_cost_store.sv
module lin_cost_store #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned COST_W = 3,
  parameter int unsigned IDX_W  = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_way,
  input  logic [COST_W-1:0]            wr_cost,
  output logic [WAYS-1:0][COST_W-1:0]  cost_q
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cost
    logic we;
    assign we = wr_en && (wr_way == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cost_q[g] <= '0;
      end else if (we) begin
        cost_q[g] <= wr_cost;
      end
    end
  end
endmodule

// File: rtl/lin_score_argmin.sv
module lin_score_argmin #(
  parameter int unsigned WAYS     = 16,
  parameter int unsigned POS_W    = $clog2(WAYS),
  parameter int unsigned IDX_W    = $clog2(WAYS),
  parameter int unsigned COST_W   = 3,
  parameter int unsigned WEIGHT_W = 3,
  parameter int unsigned SCORE_W  = POS_W + COST_W + WEIGHT_W + 1
) (
  input  logic [WAYS-1:0][POS_W-1:0]   pos,
  input  logic [WAYS-1:0][COST_W-1:0]  cost,
  input  logic [WAYS-1:0]              valid,
  input  logic [WEIGHT_W-1:0]          weight,
  output logic [IDX_W-1:0]             pick
);
  localparam int unsigned KEY_W = SCORE_W + 1;

  logic [WAYS-1:0][KEY_W-1:0] key;

  // Key MSB = valid, so every invalid way (key 0) sorts ahead of any valid one.
  for (genvar g = 0; g < WAYS; g++) begin : g_score
    logic [SCORE_W-1:0] score;
    assign score  = SCORE_W'(pos[g]) + SCORE_W'(weight) * SCORE_W'(cost[g]);
    assign key[g] = valid[g] ? {1'b1, score} : '0;
  end

  logic [KEY_W-1:0] best_key;

  always_comb begin
    best_key = key[0];
    pick     = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (key[i] < best_key) begin
        best_key = key[i];
        pick     = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lin_victim_select.sv
module lin_victim_select #(
  parameter int unsigned WAYS     = lin_pkg::LIN_WAYS_DEF,
  parameter int unsigned COST_W   = lin_pkg::LIN_COST_W_DEF,
  parameter int unsigned WEIGHT_W = lin_pkg::LIN_WEIGHT_W_DEF,
  parameter int unsigned IDX_W    = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_en,
  input  logic [IDX_W-1:0]     hit_way,
  input  logic                 fill_en,
  input  logic [IDX_W-1:0]     fill_way,
  input  logic [COST_W-1:0]    fill_cost,
  input  logic [WAYS-1:0]      way_valid,
  input  logic                 mode_lru,
  input  logic [WEIGHT_W-1:0]  cost_weight,
  output logic [IDX_W-1:0]     victim_way
);
  localparam int unsigned POS_W   = $clog2(WAYS);
  localparam int unsigned SCORE_W = lin_pkg::lin_score_w(POS_W, COST_W, WEIGHT_W);

  logic                         upd_en;
  logic [IDX_W-1:0]             upd_way;
  logic [WEIGHT_W-1:0]          eff_weight;
  logic [WAYS-1:0][POS_W-1:0]   pos_q;
  logic [WAYS-1:0][COST_W-1:0]  cost_q;

  // A fill takes priority over a hit in the same cycle.
  assign upd_en     = hit_en | fill_en;
  assign upd_way    = fill_en ? fill_way : hit_way;
  assign eff_weight = mode_lru ? '0 : cost_weight;

  lin_recency_stack #(.WAYS(WAYS), .POS_W(POS_W), .IDX_W(IDX_W)) u_stack (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_way (upd_way),
    .pos_q   (pos_q)
  );

  lin_cost_store #(.WAYS(WAYS), .COST_W(COST_W), .IDX_W(IDX_W)) u_cost (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fill_en),
    .wr_way  (fill_way),
    .wr_cost (fill_cost),
    .cost_q  (cost_q)
  );

  lin_score_argmin #(
    .WAYS(WAYS), .POS_W(POS_W), .IDX_W(IDX_W),
    .COST_W(COST_W), .WEIGHT_W(WEIGHT_W), .SCORE_W(SCORE_W)
  ) u_argmin (
    .pos    (pos_q),
    .cost   (cost_q),
    .valid  (way_valid),
    .weight (eff_weight),
    .pick   (victim_way)
  );
endmodule

// File: rtl/lin_victim_checker.sv
module lin_victim_checker #(
  parameter int unsigned WAYS   = 16,
  parameter int unsigned COST_W = 3,
  parameter int unsigned POS_W  = $clog2(WAYS),
  parameter int unsigned IDX_W  = $clog2(WAYS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hit_en,
  input logic [IDX_W-1:0]             hit_way,
  input logic                         fill_en,
  input logic [IDX_W-1:0]             fill_way,
  input logic [COST_W-1:0]            fill_cost,
  input logic [WAYS-1:0]              way_valid,
  input logic                         mode_lru,
  input logic [IDX_W-1:0]             victim_way,
  input logic [WAYS-1:0][POS_W-1:0]   pos_q,
  input logic [WAYS-1:0][COST_W-1:0]  cost_q
);
  logic perm_ok;

  always_comb begin
    perm_ok = 1'b1;
    for (int v = 0; v < WAYS; v++) begin
      int n;
      n = 0;
      for (int i = 0; i < WAYS; i++) begin
        if (pos_q[i] == POS_W'(v)) n++;
      end
      if (n != 1) perm_ok = 1'b0;
    end
  end

  // R2: positions always form a permutation of 0..WAYS-1
  assert_stack_permutation_R2: assert property (@(posedge clk) disable iff (!rst_n)
    perm_ok);

  // R2, R8: the updated way (fill first) becomes most recently used
  assert_touch_to_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_en || fill_en) |=> pos_q[$past(fill_en ? fill_way : hit_way)] == POS_W'(WAYS - 1));

  // R3: a fill records its cost
  assert_fill_cost_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> cost_q[$past(fill_way)] == $past(fill_cost));

  // R9: no update leaves the state alone
  assert_idle_holds_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_en && !fill_en) |=> ($stable(pos_q) && $stable(cost_q)));

  // R6: an invalid way is chosen whenever one exists
  assert_invalid_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (way_valid != '1) |-> !way_valid[victim_way]);

  // R5: in LRU mode with a full set the victim holds position 0
  assert_lru_mode_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lru && way_valid == '1) |-> pos_q[victim_way] == '0);
endmodule

bind lin_victim_select lin_victim_checker #(
  .WAYS(WAYS), .COST_W(COST_W), .POS_W(POS_W), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_en     (hit_en),
  .hit_way    (hit_way),
  .fill_en    (fill_en),
  .fill_way   (fill_way),
  .fill_cost  (fill_cost),
  .way_valid  (way_valid),
  .mode_lru   (mode_lru),
  .victim_way (victim_way),
  .pos_q      (pos_q),
  .cost_q     (cost_q)
);

// File: tb/lin_victim_select_tb.sv
`timescale 1ns/1ps
module lin_victim_select_tb;
  localparam int WAYS = 16, COST_W = 3, WEIGHT_W = 3, IDX_W = 4;

  logic                clk, rst_n;
  logic                hit_en, fill_en, mode_lru;
  logic [IDX_W-1:0]    hit_way, fill_way;
  logic [COST_W-1:0]   fill_cost;
  logic [WAYS-1:0]     way_valid;
  logic [WEIGHT_W-1:0] cost_weight;
  logic [IDX_W-1:0]    victim_way;

  lin_victim_select #(.WAYS(WAYS), .COST_W(COST_W), .WEIGHT_W(WEIGHT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_en(hit_en), .hit_way(hit_way),
    .fill_en(fill_en), .fill_way(fill_way), .fill_cost(fill_cost),
    .way_valid(way_valid), .mode_lru(mode_lru), .cost_weight(cost_weight),
    .victim_way(victim_way)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int exp; string tag; } item_t;
  item_t sb[$];
  int ref_pos[WAYS];
  int ref_cost[WAYS];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int model_victim(input logic [WAYS-1:0] v, input bit lru, input int wt);
    int best, best_key;
    best = 0; best_key = 1 << 30;
    for (int i = 0; i < WAYS; i++) begin
      int k;
      k = v[i] ? (1000 + ref_pos[i] + (lru ? 0 : wt) * ref_cost[i]) : 0;
      if (k < best_key) begin best_key = k; best = i; end
    end
    return best;
  endfunction

  function automatic void model_promote(input int w);
    int old;
    old = ref_pos[w];
    for (int i = 0; i < WAYS; i++) begin
      if (i == w) ref_pos[i] = WAYS - 1;
      else if (ref_pos[i] > old) ref_pos[i] = ref_pos[i] - 1;
    end
  endfunction

  // Driver: apply one cycle of stimulus, update model, queue expected victim.
  task automatic step(input bit h, input int hw, input bit f, input int fw, input int fc,
                      input logic [WAYS-1:0] vm, input bit lru, input int wt, input string tag);
    item_t it;
    @(negedge clk); #1;
    hit_en = h; hit_way = IDX_W'(hw);
    fill_en = f; fill_way = IDX_W'(fw); fill_cost = COST_W'(fc);
    way_valid = vm; mode_lru = lru; cost_weight = WEIGHT_W'(wt);
    @(posedge clk); #1;
    hit_en = 1'b0; fill_en = 1'b0;
    if (f) begin model_promote(fw); ref_cost[fw] = fc; end
    else if (h) model_promote(hw);
    it.exp = model_victim(vm, lru, wt);
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare at the falling edge after the update edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (victim_way !== IDX_W'(it.exp)) begin
        errors++;
        $display("FAIL %s: victim_way=%0d expected %0d", it.tag, victim_way, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    logic [WAYS-1:0] all_v;
    all_v = '1;
    rst_n = 1'b0; hit_en = 0; fill_en = 0; hit_way = '0; fill_way = '0;
    fill_cost = '0; way_valid = '1; mode_lru = 0; cost_weight = '0;
    for (int i = 0; i < WAYS; i++) begin ref_pos[i] = i; ref_cost[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, victim 0 for any weight
    step(0, 0, 0, 0, 0, all_v, 0, 7, "R1 reset weight7");
    step(0, 0, 0, 0, 0, all_v, 1, 0, "R1 reset lru");

    // R7: build a tie between way 1 (pos0,cost1) and way 2 (pos1,cost0) at S=1
    step(0, 0, 1, 1, 1, all_v, 1, 0, "R3 fill way1 cost1");
    for (int w = 2; w < WAYS; w++) step(1, w, 0, 0, 0, all_v, 1, 0, "R2 hit sweep");
    step(1, 0, 0, 0, 0, all_v, 1, 0, "R2 hit way0");
    step(0, 0, 0, 0, 0, all_v, 0, 1, "R7 tie lowest index");
    step(0, 0, 0, 0, 0, all_v, 0, 2, "R4 weight2 skips costly way");
    step(0, 0, 0, 0, 0, all_v, 1, 7, "R5 lru ignores weight");

    // R3: fill with a high cost protects a way
    step(0, 0, 1, 2, 7, all_v, 0, 3, "R3 fill way2 cost7");
    step(1, 3, 0, 0, 0, all_v, 0, 3, "R2 hit way3");
    step(0, 0, 0, 0, 0, all_v, 0, 3, "R9 idle hold");
    step(0, 0, 0, 0, 0, all_v, 0, 3, "R9 idle hold again");

    // R6: invalid ways first, lowest index
    step(0, 0, 0, 0, 0, 16'hFDDF, 0, 3, "R6 invalid ways 5 and 9");
    step(0, 0, 0, 0, 0, 16'h7FFF, 1, 0, "R6 invalid way 15");

    // R8: simultaneous hit and fill, only the fill applies
    step(1, 4, 1, 6, 5, all_v, 1, 0, "R8 fill wins over hit");
    step(0, 0, 0, 0, 0, all_v, 0, 1, "R8 after collision");

    // R4: pseudo-random mix
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [WAYS-1:0] vm;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      vm = (lfsr[2:0] == 3'd0) ? (all_v ^ (16'h1 << lfsr[11:8])) : all_v;
      step(lfsr[3], int'(lfsr[7:4]), lfsr[4] & lfsr[5], int'(lfsr[11:8]),
           int'(lfsr[14:12]), vm, lfsr[15] & lfsr[1], int'(lfsr[6:4]), "R4 random mix");
    end

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule